// File: doc/BRIEF.md
# SDRAM Controller with Open-Row Tracking

This block sits between a simple memory-mapped request port and one single-data-rate SDRAM device. The requester sees a flat word-addressed space: it raises a read or a write with an address and holds it until the block stops stalling. Reads are pipelined. A new read can be taken every cycle while its row is open, and the data comes back in request order with a one-cycle valid strobe, a fixed number of cycles later.

After reset the block powers the device up on its own. It waits out a stable period, closes every bank, runs two refresh cycles and programs the mode register. From then on it keeps one row open per bank and reuses it whenever an access hits. On a miss it closes the old row and opens the new one, observing the parameterized precharge and activate delays. A free-running interval counter raises periodic refresh requests. Each request is served ahead of any pending access.

The device data bus is shared in both directions. Write data goes out in the same cycle as the WRITE command, while read data returns CAS-latency cycles after the READ. The block therefore holds back any write until no read can still be returning data. The clock enable is never lowered. There are no software-visible registers: all timing comes from parameters. The reset input is applied asynchronously, and its release is expected to be synchronized outside the block.

Top module: `sdc_top`

## Requirements
- R1: Device commands are encoded on {ras_n, cas_n, we_n} as: mode load 000, refresh 001, precharge 010, activate 011, write 100, read 101, no-op 111. While reset is high, chip select is high, clock enable is high, the port stalls and no read valid is shown. Clock enable stays high at all times.
- R2: After reset, no command other than no-op is issued for at least T_INIT cycles. The first four commands are then, in order: a precharge with address bit 10 set (all banks), refresh, refresh, and mode load with address bits [6:4] equal to CAS and all other address bits zero. The port stalls until this sequence is done.
- R3: The port address is split as {row, bank, column}, with the column in the low bits. A read returns the data last written to the same port address.
- R4: A read accepted at clock edge k shows its data on rsp_data with rsp_valid high in the cycle after edge k+CAS+1. Reads to an open row are accepted on consecutive cycles, and data returns in the order of acceptance.
- R5: An access whose row is already open in its bank is issued as READ or WRITE with no precharge or activate in front of it.
- R6: An access to a bank holding a different open row causes a precharge of that bank. An activate follows no earlier than T_RP cycles later, and the READ or WRITE no earlier than T_RCD cycles after the activate. An activate never targets a bank that already has a row open.
- R7: An access to a bank with no open row is preceded by an activate only, with no precharge.
- R8: A WRITE command is issued only when more than CAS cycles have passed since the last READ command. The controller never drives the data bus in a cycle in which read data is due.
- R9: Refresh requests arise every T_REFI cycles. Each is served by a precharge-all followed T_RP or more cycles later by a refresh. No further command follows for T_RFC cycles. Open rows are reopened on demand afterwards, and stored data is kept.
- R10: Write data is driven on the data bus in the same device cycle as its WRITE command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high reset, asserted asynchronously |
| cmd_rd | input | 1 | Read request, held until accepted |
| cmd_wr | input | 1 | Write request, held until accepted |
| cmd_addr | input | ROW_W+BANK_W+COL_W | Flat word address {row, bank, column} |
| cmd_wdata | input | DATA_W | Write data |
| cmd_busy | output | 1 | Stall: request is not accepted this cycle |
| rsp_data | output | DATA_W | Read data in request order |
| rsp_valid | output | 1 | rsp_data holds a read result this cycle |
| mem_cke | output | 1 | Device clock enable, always high |
| mem_cs_n | output | 1 | Device chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ba | output | BANK_W | Bank address |
| mem_a | output | A_W | Row / column / mode address |
| mem_dq | inout | DATA_W | Bidirectional data bus |

## Verification
Directed accesses follow the power-up sequence and run in a fixed order. A first touch of a closed bank, a second access to the same row and an access to another row in the same bank separate the activate-only, hit and precharge-then-activate paths. A run of reads to one row tells real pipelining apart from one-at-a-time service. A read followed at once by a write probes the bus interlock. Seeded random mixes of reads and writes over the whole address space then exercise every bank and row transition against a reference memory, and a long idle stretch followed by readback shows that refresh fires on time and that data and row reopening survive it.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

    // device command on {ras_n, cas_n, we_n}
    typedef enum logic [2:0] {
        CMD_MRS = 3'b000,
        CMD_REF = 3'b001,
        CMD_PRE = 3'b010,
        CMD_ACT = 3'b011,
        CMD_WR  = 3'b100,
        CMD_RD  = 3'b101,
        CMD_NOP = 3'b111
    } sdc_cmd_e;

    typedef enum logic [2:0] {
        S_PWR, S_WAIT, S_PALL, S_REF1, S_REF2, S_MODE, S_ACT, S_IDLE
    } sdc_state_e;

    // wait-state load for a command-to-command distance of d cycles
    function automatic int unsigned gap_load(int unsigned d);
        return (d < 2) ? 0 : d - 2;
    endfunction

endpackage

// File: rtl/sdc_refresh_timer.sv
module sdc_refresh_timer #(
    parameter int T_REFI = 390
) (
    input  logic clk,
    input  logic rst,
    input  logic ack,
    output logic req
);
    localparam int W = $clog2(T_REFI + 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            cnt <= W'(T_REFI - 1);
            req <= 1'b0;
        end else if (cnt == '0) begin
            cnt <= W'(T_REFI - 1);
            req <= 1'b1;
        end else begin
            cnt <= cnt - 1'b1;
            if (ack) req <= 1'b0;
        end
    end

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (req && !ack) |=> req);

endmodule

// File: rtl/sdc_row_table.sv
module sdc_row_table #(
    parameter int BANK_W = 2,
    parameter int ROW_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BANK_W-1:0] bank,
    input  logic [ROW_W-1:0]  row,
    input  logic              act_en,
    input  logic              pre_en,
    input  logic              pre_all,
    output logic              hit,
    output logic              bank_open,
    output logic              any_open
);
    localparam int NB = 1 << BANK_W;

    logic [NB-1:0] vld;
    logic [ROW_W-1:0] row_q [NB];

    for (genvar b = 0; b < NB; b++) begin : g_bank
        always_ff @(posedge clk or posedge rst) begin
            if (rst) begin
                vld[b]   <= 1'b0;
                row_q[b] <= '0;
            end else if (pre_all || (pre_en && bank == BANK_W'(b))) begin
                vld[b]   <= 1'b0;
            end else if (act_en && bank == BANK_W'(b)) begin
                vld[b]   <= 1'b1;
                row_q[b] <= row;
            end
        end
    end

    assign bank_open = vld[bank];
    assign hit       = vld[bank] && (row_q[bank] == row);
    assign any_open  = |vld;

    // R6
    act_closed_chk: assert property (@(posedge clk) disable iff (rst)
        act_en |-> !vld[bank]);

endmodule

// File: rtl/sdc_read_pipe.sv
module sdc_read_pipe #(
    parameter int CAS    = 2,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue,
    input  logic [DATA_W-1:0] dq_in,
    output logic              inflight,
    output logic              capture,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_valid
);
    logic [CAS:0] sr;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            sr        <= '0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            sr        <= {sr[CAS-1:0], issue};
            rsp_valid <= sr[CAS];
            if (sr[CAS]) rsp_data <= dq_in;
        end
    end

    assign capture  = sr[CAS];
    assign inflight = |sr;

endmodule

// File: rtl/sdc_top.sv
module sdc_top
    import sdc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ROW_W  = 4,
    parameter int BANK_W = 2,
    parameter int COL_W  = 4,
    parameter int A_W    = 12,
    parameter int CAS    = 2,
    parameter int T_INIT = 20,
    parameter int T_RP   = 2,
    parameter int T_RCD  = 2,
    parameter int T_RFC  = 6,
    parameter int T_MRD  = 2,
    parameter int T_REFI = 390
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cmd_rd,
    input  logic                          cmd_wr,
    input  logic [ROW_W+BANK_W+COL_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0]             cmd_wdata,
    output logic                          cmd_busy,
    output logic [DATA_W-1:0]             rsp_data,
    output logic                          rsp_valid,
    output logic                          mem_cke,
    output logic                          mem_cs_n,
    output logic                          mem_ras_n,
    output logic                          mem_cas_n,
    output logic                          mem_we_n,
    output logic [BANK_W-1:0]             mem_ba,
    output logic [A_W-1:0]                mem_a,
    inout  wire  [DATA_W-1:0]             mem_dq
);
    localparam int CNT_W = $clog2(T_INIT + T_RFC + T_RP + T_RCD + T_MRD + 2);

    logic [COL_W-1:0]  col;
    logic [BANK_W-1:0] bank;
    logic [ROW_W-1:0]  row;
    assign col  = cmd_addr[COL_W-1:0];
    assign bank = cmd_addr[COL_W +: BANK_W];
    assign row  = cmd_addr[COL_W+BANK_W +: ROW_W];

    sdc_state_e       st, st_d, nxt, nxt_d;
    logic [CNT_W-1:0] cnt, cnt_d;
    logic             init_done;
    sdc_cmd_e         cmd_q, cmd_d;
    logic [A_W-1:0]   a_d;
    logic             act_en, pre_en, pre_all, rd_go, wr_go, ref_ack;
    logic             ref_req, hit, bank_open, any_open;
    logic             inflight, capture, dq_oe;
    logic [DATA_W-1:0] wdq;

    sdc_refresh_timer #(.T_REFI(T_REFI)) u_ref (
        .clk(clk), .rst(rst), .ack(ref_ack), .req(ref_req));

    sdc_row_table #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_rows (
        .clk(clk), .rst(rst), .bank(bank), .row(row),
        .act_en(act_en), .pre_en(pre_en), .pre_all(pre_all),
        .hit(hit), .bank_open(bank_open), .any_open(any_open));

    sdc_read_pipe #(.CAS(CAS), .DATA_W(DATA_W)) u_rdp (
        .clk(clk), .rst(rst), .issue(rd_go), .dq_in(mem_dq),
        .inflight(inflight), .capture(capture),
        .rsp_data(rsp_data), .rsp_valid(rsp_valid));

    always_comb begin
        st_d = st;  nxt_d = nxt;  cnt_d = cnt;
        cmd_d = CMD_NOP;  a_d = '0;
        act_en = 1'b0;  pre_en = 1'b0;  pre_all = 1'b0;
        rd_go = 1'b0;   wr_go = 1'b0;   ref_ack = 1'b0;
        unique case (st)
            S_PWR, S_WAIT: begin
                if (cnt == '0) st_d = (st == S_PWR) ? S_PALL : nxt;
                else cnt_d = cnt - 1'b1;
            end
            S_PALL: begin
                cmd_d = CMD_PRE;  a_d[10] = 1'b1;  pre_all = 1'b1;
                st_d = S_WAIT;  nxt_d = init_done ? S_REF2 : S_REF1;
                cnt_d = CNT_W'(gap_load(T_RP));
            end
            S_REF1, S_REF2: begin
                cmd_d = CMD_REF;  ref_ack = 1'b1;  st_d = S_WAIT;
                nxt_d = (st == S_REF1) ? S_REF2 : (init_done ? S_IDLE : S_MODE);
                cnt_d = CNT_W'(gap_load(T_RFC));
            end
            S_MODE: begin
                cmd_d = CMD_MRS;  a_d[6:4] = 3'(CAS);
                st_d = S_WAIT;  nxt_d = S_IDLE;
                cnt_d = CNT_W'(gap_load(T_MRD));
            end
            S_ACT: begin
                cmd_d = CMD_ACT;  a_d[ROW_W-1:0] = row;  act_en = 1'b1;
                st_d = S_WAIT;  nxt_d = S_IDLE;
                cnt_d = CNT_W'(gap_load(T_RCD));
            end
            S_IDLE: begin
                if (ref_req) begin
                    st_d = S_PALL;
                end else if (cmd_rd || cmd_wr) begin
                    if (hit) begin
                        a_d[COL_W-1:0] = col;
                        if (cmd_rd) begin
                            cmd_d = CMD_RD;  rd_go = 1'b1;
                        end else if (!inflight) begin
                            cmd_d = CMD_WR;  wr_go = 1'b1;
                        end
                    end else if (bank_open) begin
                        cmd_d = CMD_PRE;  pre_en = 1'b1;
                        st_d = S_WAIT;  nxt_d = S_ACT;
                        cnt_d = CNT_W'(gap_load(T_RP));
                    end else begin
                        cmd_d = CMD_ACT;  a_d[ROW_W-1:0] = row;  act_en = 1'b1;
                        st_d = S_WAIT;  nxt_d = S_IDLE;
                        cnt_d = CNT_W'(gap_load(T_RCD));
                    end
                end
            end
            default: st_d = S_PWR;
        endcase
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            st        <= S_PWR;
            nxt       <= S_IDLE;
            cnt       <= CNT_W'(T_INIT - 1);
            init_done <= 1'b0;
            cmd_q     <= CMD_NOP;
            mem_cs_n  <= 1'b1;
            mem_a     <= '0;
            mem_ba    <= '0;
            dq_oe     <= 1'b0;
            wdq       <= '0;
        end else begin
            st       <= st_d;
            nxt      <= nxt_d;
            cnt      <= cnt_d;
            if (st == S_MODE) init_done <= 1'b1;
            cmd_q    <= cmd_d;
            mem_cs_n <= 1'b0;
            mem_a    <= a_d;
            mem_ba   <= bank;
            dq_oe    <= wr_go;
            if (wr_go) wdq <= cmd_wdata;
        end
    end

    assign cmd_busy  = !(rd_go || wr_go);
    assign mem_cke   = 1'b1;
    assign {mem_ras_n, mem_cas_n, mem_we_n} = cmd_q;
    assign mem_dq    = dq_oe ? wdq : 'z;

    // R8
    wr_no_rd_pending_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_q == CMD_WR) |-> !inflight);

    // R8
    bus_one_driver_chk: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> !capture);

    // R4
    rd_latency_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(cmd_q == CMD_RD, CAS + 1));

    // R9
    ref_all_closed_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_q == CMD_REF) |-> !any_open);

endmodule

// File: tb/sim_sdc_top.sv
`timescale 1ns/1ps
module sim_sdc_top;
    localparam int DW = 16, CL = 2, TINIT = 20, TRP = 2, TRCD = 2;
    localparam int TRFC = 6, TMRD = 2, TREFI = 390;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic          cmd_rd = 0, cmd_wr = 0, cmd_busy, rsp_valid;
    logic [9:0]    cmd_addr = '0;
    logic [DW-1:0] cmd_wdata = '0, rsp_data;
    logic          cke, cs_n, ras_n, cas_n, we_n;
    logic [1:0]    ba;
    logic [11:0]   ma;
    wire  [DW-1:0] dq;

    sdc_top #(.DATA_W(DW), .ROW_W(4), .BANK_W(2), .COL_W(4), .A_W(12),
              .CAS(CL), .T_INIT(TINIT), .T_RP(TRP), .T_RCD(TRCD),
              .T_RFC(TRFC), .T_MRD(TMRD), .T_REFI(TREFI)) u0 (
        .clk(clk), .rst(rst), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_busy(cmd_busy),
        .rsp_data(rsp_data), .rsp_valid(rsp_valid), .mem_cke(cke),
        .mem_cs_n(cs_n), .mem_ras_n(ras_n), .mem_cas_n(cas_n),
        .mem_we_n(we_n), .mem_ba(ba), .mem_a(ma), .mem_dq(dq));

    int n_check = 0, n_fail = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_check++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [9:0] flat(input int row, input int bnk, input int col);
        return 10'((row << 6) | (bnk << 4) | col);
    endfunction

    // ---------------- device model ----------------
    logic [DW-1:0] dram [1024];
    logic [DW-1:0] refm [1024];
    logic [3:0]    p_v = '0;
    logic [DW-1:0] p_d [4];
    assign dq = p_v[CL-1] ? p_d[CL-1] : 'z;

    int cyc = 0, n_cmd = 0, n_act = 0, n_pre1 = 0, n_ref = 0, first_cyc = -1;
    int last_rd = -100, last_ref = -100, t_pall = -100;
    int t_act [4], t_pre [4], orow [4];
    bit opn [4];
    logic [2:0]  log_c [4];
    logic [11:0] log_a [4];

    initial begin
        for (int i = 0; i < 1024; i++) begin dram[i] = '0; refm[i] = '0; end
        for (int b = 0; b < 4; b++) begin
            t_act[b] = -100; t_pre[b] = -100; orow[b] = 0; opn[b] = 0;
        end
        for (int i = 0; i < 4; i++) p_d[i] = '0;
    end

    always @(posedge clk) begin
        logic [2:0] c;
        logic       is_rd;
        cyc++;
        c = {ras_n, cas_n, we_n};
        is_rd = 1'b0;
        if (!rst && !cs_n && c != 3'b111) begin
            if (n_cmd < 4) begin log_c[n_cmd] = c; log_a[n_cmd] = ma; end
            if (n_cmd == 0) first_cyc = cyc;
            n_cmd++;
            chk(cyc - last_ref >= TRFC, "R9", "cycles after refresh", cyc - last_ref, TRFC);
            case (c)
                3'b011: begin
                    chk(!opn[ba], "R6", "activate on open bank", opn[ba], 0);
                    chk(cyc - t_pre[ba] >= TRP, "R6", "precharge to activate", cyc - t_pre[ba], TRP);
                    opn[ba] = 1; orow[ba] = int'(ma[3:0]); t_act[ba] = cyc; n_act++;
                end
                3'b010: begin
                    if (ma[10]) begin
                        for (int b = 0; b < 4; b++) begin opn[b] = 0; t_pre[b] = cyc; end
                        t_pall = cyc;
                    end else begin
                        opn[ba] = 0; t_pre[ba] = cyc; n_pre1++;
                    end
                end
                3'b001: begin
                    chk(!(opn[0] | opn[1] | opn[2] | opn[3]), "R9", "refresh with open bank", 1, 0);
                    chk(cyc - t_pall >= TRP, "R9", "precharge-all to refresh", cyc - t_pall, TRP);
                    if (n_ref >= 2)
                        chk(cyc - last_ref <= TREFI + 40, "R9", "refresh interval", cyc - last_ref, TREFI);
                    last_ref = cyc; n_ref++;
                end
                3'b101, 3'b100: begin
                    chk(opn[ba], "R5", "column access on closed bank", opn[ba], 1);
                    chk(cyc - t_act[ba] >= TRCD, "R6", "activate to column", cyc - t_act[ba], TRCD);
                    if (c == 3'b101) begin
                        is_rd = 1'b1; last_rd = cyc;
                    end else begin
                        chk(cyc - last_rd > CL, "R8", "read to write gap", cyc - last_rd, CL + 1);
                        chk(!p_v[CL-1], "R8", "bus contention", p_v[CL-1], 0);
                        chk(!$isunknown(dq), "R10", "write data on bus", 0, 0);
                        dram[flat(orow[ba], ba, ma[3:0])] = dq;
                    end
                end
                default: ;
            endcase
        end
        p_v <= {p_v[2:0], is_rd};
        p_d[0] <= dram[flat(orow[ba], ba, ma[3:0])];
        for (int i = 1; i < 4; i++) p_d[i] <= p_d[i-1];
    end

    // ---------------- scoreboard ----------------
    logic [DW-1:0] exp_q [$];
    int            acc_q [$];

    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (exp_q.size() == 0) begin
                chk(0, "R4", "unexpected read data", rsp_data, 0);
            end else begin
                logic [DW-1:0] e;
                int a;
                e = exp_q.pop_front(); a = acc_q.pop_front();
                chk(rsp_data == e, "R3", "read data", rsp_data, e);
                chk(cyc - a == CL + 1, "R4", "read latency", cyc - a, CL + 1);
            end
        end
    end

    task automatic issue(input bit w, input logic [9:0] a, input logic [DW-1:0] d,
                         output int acc);
        @(negedge clk);
        cmd_rd = !w; cmd_wr = w; cmd_addr = a; cmd_wdata = d;
        #0.1;
        while (cmd_busy) begin @(negedge clk); #0.1; end
        acc = cyc + 1;
        if (w) refm[a] = d;
        else begin exp_q.push_back(refm[a]); acc_q.push_back(acc); end
        @(posedge clk);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        cmd_rd = 0; cmd_wr = 0;
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_check, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "ALL", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int acc, a0, a1, na, np, nr;
        int accs [4];
        void'($urandom(32'd2024));

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(cs_n == 1'b1, "R1", "cs_n in reset", cs_n, 1);
        chk(cke == 1'b1, "R1", "cke in reset", cke, 1);
        chk(cmd_busy == 1'b1, "R1", "busy in reset", cmd_busy, 1);
        chk(rsp_valid == 1'b0, "R1", "rsp_valid in reset", rsp_valid, 0);
        rst = 1'b0;

        // R2: power-up sequence
        wait (n_cmd >= 4);
        repeat (4) @(negedge clk);
        chk(first_cyc - 3 >= TINIT, "R2", "quiet cycles before first command", first_cyc - 3, TINIT);
        chk(log_c[0] == 3'b010 && log_a[0][10], "R2", "first is precharge-all", log_c[0], 2);
        chk(log_c[1] == 3'b001, "R2", "second is refresh", log_c[1], 1);
        chk(log_c[2] == 3'b001, "R2", "third is refresh", log_c[2], 1);
        chk(log_c[3] == 3'b000, "R2", "fourth is mode load", log_c[3], 0);
        chk(log_a[3] == 12'(CL << 4), "R2", "mode word", log_a[3], CL << 4);
        chk(cke == 1'b1, "R1", "cke after init", cke, 1);

        // R7: closed bank -> activate only
        na = n_act; np = n_pre1;
        issue(1, flat(3, 1, 2), 16'hA5C3, acc); idle(2);
        chk(n_act - na == 1, "R7", "activates on closed bank", n_act - na, 1);
        chk(n_pre1 - np == 0, "R7", "precharges on closed bank", n_pre1 - np, 0);

        // R5: row hit
        na = n_act; np = n_pre1;
        issue(1, flat(3, 1, 3), 16'h1234, acc); idle(2);
        chk(n_act - na == 0 && n_pre1 - np == 0, "R5", "row commands on hit",
            n_act - na + n_pre1 - np, 0);

        // R6: row miss in same bank
        na = n_act; np = n_pre1;
        issue(0, flat(5, 1, 0), '0, acc); idle(2);
        chk(n_act - na == 1 && n_pre1 - np == 1, "R6", "precharge+activate on miss",
            n_act - na + n_pre1 - np, 2);

        // R3: readback after row change
        issue(0, flat(3, 1, 2), '0, acc);
        issue(0, flat(3, 1, 3), '0, acc); idle(6);

        // R4: back-to-back pipelined reads
        issue(0, flat(3, 1, 4), '0, accs[0]);
        for (int i = 1; i < 4; i++) issue(0, flat(3, 1, 4 + i), '0, accs[i]);
        idle(6);
        chk(accs[3] - accs[0] == 3, "R4", "four reads in consecutive cycles", accs[3] - accs[0], 3);

        // R8: write right after read
        issue(0, flat(3, 1, 2), '0, a0);
        issue(1, flat(3, 1, 9), 16'hBEEF, a1); idle(2);
        chk(a1 - a0 > CL + 1, "R8", "write held behind read", a1 - a0, CL + 2);
        issue(0, flat(3, 1, 9), '0, acc); idle(6);

        // random mix
        for (int i = 0; i < 400; i++) begin
            issue(($urandom % 2) == 1, 10'($urandom % 1024), 16'($urandom), acc);
            if (($urandom % 4) == 0) idle($urandom % 3);
        end
        idle(8);

        // R9: refresh while idle, data kept
        nr = n_ref;
        repeat (2 * TREFI + 60) @(negedge clk);
        chk(n_ref - nr >= 2, "R9", "refreshes while idle", n_ref - nr, 2);
        issue(0, flat(3, 1, 2), '0, acc);
        issue(0, flat(3, 1, 9), '0, acc);
        issue(0, flat(5, 1, 0), '0, acc);
        idle(10);

        chk(exp_q.size() == 0, "R4", "reads left unanswered", exp_q.size(), 0);
        finish_run();
    end
endmodule